// File: doc/BRIEF.md
# PS/2 Keyboard Byte Receiver with Host Read Handshake

This block takes the two open-collector lines of a PS/2 keyboard, the keyboard clock and the keyboard data, and recovers the bytes the keyboard sends. Both lines are brought into the system clock domain through a two-stage synchroniser. A bit is taken from the data line on each falling edge of the synchronised keyboard clock. A small state machine assembles each eleven-bit frame. A frame that passes its parity and stop checks is copied into a holding register. A frame that fails either check is thrown away.

A data-available flag tells the host that an unread byte is waiting. The flag stays set until the host pulses the read-complete acknowledge input. If a new byte lands while the flag is still set, the new byte replaces the old one and a sticky overrun bit is raised. The host reads either the holding register or a status word through a one-cycle registered read port. A watchdog counter returns the receiver to idle when the keyboard clock stops partway through a frame, so a broken frame cannot shift the bits of the next one.

The frame state machine has four states. ST_IDLE waits for a start bit. ST_DATA collects eight data bits. ST_PARITY takes the parity bit. ST_STOP takes the stop bit and judges the frame. The transitions are:
- T_START: ST_IDLE to ST_DATA, on a falling edge with the data line low.
- T_BIT: ST_DATA to itself, on each of the first seven data bits.
- T_LAST: ST_DATA to ST_PARITY, on the eighth data bit.
- T_PAR: ST_PARITY to ST_STOP, on the parity bit.
- T_END: ST_STOP to ST_IDLE, on the stop bit, whether the frame is accepted or dropped.
- T_TMO: from ST_DATA, ST_PARITY or ST_STOP back to ST_IDLE when no edge arrives within TIMEOUT_CYC system clocks.

Top module: `ps2_rx_hold`

## Requirements
- R1: After reset, data_avail_o and overrun_o are 0, rd_data_o is 0, and both the holding register and the status word read back as 0.
- R2: A frame consists of a start bit (0), then eight data bits sent least significant bit first, then a parity bit that makes the count of ones across the data and parity bits odd, then a stop bit (1). Such a frame loads its byte into the holding register and sets data_avail_o.
- R3: A frame whose parity bit is wrong is discarded. data_avail_o and the holding register keep their previous values.
- R4: A frame whose stop bit is 0 is discarded. data_avail_o and the holding register keep their previous values.
- R5: A falling keyboard-clock edge with the data line high while idle is not taken as a start bit. A well-formed frame that follows is received correctly.
- R6: A one-cycle pulse on rd_ack_i clears data_avail_o on the next clock, unless a new byte completes in that same cycle. The holding register keeps its value.
- R7: If a byte completes while data_avail_o is set and rd_ack_i is low, the holding register takes the new byte and overrun_o becomes 1. overrun_o stays 1 until it is cleared.
- R8: When rd_en_i is high at a clock edge, rd_data_o presents on the next cycle:
  - the holding register, when rd_addr_i is 0;
  - the status word, when rd_addr_i is 1. Bit 0 of the status word is data-available, bit 1 is overrun, and the other bits are 0.

  A status read clears overrun after the read, unless a new overrun occurs in that same cycle.
- R9: If TIMEOUT_CYC system clocks pass mid-frame without a falling keyboard-clock edge, the receiver returns to idle. The partial frame is dropped, and a complete frame that follows is received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kb_clk_i | input | 1 | Keyboard clock line (asynchronous) |
| kb_dat_i | input | 1 | Keyboard data line (asynchronous) |
| rd_ack_i | input | 1 | Read-complete acknowledge pulse from the host |
| rd_en_i | input | 1 | Host read strobe |
| rd_addr_i | input | 1 | Read select: 0 selects the holding register, 1 selects the status word |
| rd_data_o | output | 8 | Registered read data |
| data_avail_o | output | 1 | An unread byte is waiting |
| overrun_o | output | 1 | Sticky flag: a byte was overwritten before it was acknowledged |

## Verification
The bench drives frames with a bad parity bit and with a low stop bit. A receiver that skipped either check would load the byte and raise data-available. The bench also sends a lone clock pulse with data high before a frame. It stops the keyboard clock after four bits and then sends a good frame. Without start qualification or the timeout, the bit count would slip and a wrong byte would be stored. For overrun, the bench sends two bytes with no acknowledge between them and reads the status word twice. A design that kept the old byte, never set overrun, or never cleared it on a status read shows the wrong holding value or the wrong status bits.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;

    localparam int unsigned BYTE_W = 8;

    // Frame receiver states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DATA   = 2'd1,
        ST_PARITY = 2'd2,
        ST_STOP   = 2'd3
    } rx_state_e;

    // Read-port address map
    localparam logic ADDR_HOLD = 1'b0;
    localparam logic ADDR_STAT = 1'b1;

endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic fall_o
);
    // One extra stage holds the previous synchronised value for edge detection
    localparam int unsigned DEPTH = STAGES + 1;

    logic [DEPTH-1:0] pipe_q;

    // Idle state of a PS/2 line is high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '1;
        end else begin
            pipe_q <= {pipe_q[DEPTH-2:0], line_i};
        end
    end

    assign level_o = pipe_q[STAGES-1];
    assign fall_o  = pipe_q[STAGES] & ~pipe_q[STAGES-1];

endmodule

// File: rtl/ps2_frame_fsm.sv
module ps2_frame_fsm
    import ps2_rx_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 12500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb_i,
    input  logic              bit_val_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              frame_ok_o,
    output logic              frame_bad_o,
    output logic              timeout_o,
    output rx_state_e         state_o
);
    localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);
    localparam int unsigned CW = $clog2(BYTE_W);
    localparam logic [TW-1:0] TMO_LIM  = TW'(TIMEOUT_CYC);
    localparam logic [CW-1:0] LAST_BIT = CW'(BYTE_W - 1);

    rx_state_e         state_q, state_d;
    logic [BYTE_W-1:0] shift_q;
    logic [CW-1:0]     cnt_q;
    logic              par_q;
    logic [TW-1:0]     gap_q;
    logic              tmo;

    assign tmo = (state_q != ST_IDLE) && !bit_stb_i && (gap_q >= TMO_LIM);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (bit_stb_i && !bit_val_i) state_d = ST_DATA;          // T_START
            end
            ST_DATA: begin
                if (tmo)                                  state_d = ST_IDLE;   // T_TMO
                else if (bit_stb_i && cnt_q == LAST_BIT)  state_d = ST_PARITY; // T_LAST
            end
            ST_PARITY: begin
                if (tmo)            state_d = ST_IDLE;   // T_TMO
                else if (bit_stb_i) state_d = ST_STOP;   // T_PAR
            end
            ST_STOP: begin
                if (tmo)            state_d = ST_IDLE;   // T_TMO
                else if (bit_stb_i) state_d = ST_IDLE;   // T_END
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Output decode: judge the frame on the stop bit
    always_comb begin
        frame_ok_o  = 1'b0;
        frame_bad_o = 1'b0;
        if (state_q == ST_STOP && bit_stb_i) begin
            if (bit_val_i && (^{shift_q, par_q})) frame_ok_o  = 1'b1;
            else                                  frame_bad_o = 1'b1;
        end
    end

    // Datapath: shift register, bit counter, parity capture and gap counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q <= '0;
            cnt_q   <= '0;
            par_q   <= 1'b0;
            gap_q   <= '0;
        end else begin
            if (state_q == ST_IDLE || bit_stb_i) gap_q <= '0;
            else if (gap_q < TMO_LIM)            gap_q <= gap_q + 1'b1;

            if (state_q == ST_IDLE) cnt_q <= '0;

            if (bit_stb_i) begin
                if (state_q == ST_DATA) begin
                    shift_q <= {bit_val_i, shift_q[BYTE_W-1:1]};
                    cnt_q   <= cnt_q + 1'b1;
                end
                if (state_q == ST_PARITY) par_q <= bit_val_i;
            end
        end
    end

    assign byte_o    = shift_q;
    assign timeout_o = tmo;
    assign state_o   = state_q;

endmodule

// File: rtl/ps2_hold_reg.sv
module ps2_hold_reg
    import ps2_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              rd_ack_i,
    input  logic              rd_en_i,
    input  logic              rd_addr_i,
    output logic [BYTE_W-1:0] hold_o,
    output logic              avail_o,
    output logic              overrun_o,
    output logic [BYTE_W-1:0] rd_data_o
);
    logic [BYTE_W-1:0] hold_q;
    logic              avail_q;
    logic              ovr_q;
    logic [BYTE_W-1:0] rdata_q;
    logic [BYTE_W-1:0] status_w;

    assign status_w = {{(BYTE_W-2){1'b0}}, ovr_q, avail_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= '0;
            avail_q <= 1'b0;
            ovr_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            // A new byte wins over an acknowledge in the same cycle
            if (byte_vld_i) begin
                hold_q  <= byte_i;
                avail_q <= 1'b1;
            end else if (rd_ack_i) begin
                avail_q <= 1'b0;
            end

            // Setting overrun wins over clearing it by a status read
            if (byte_vld_i && avail_q && !rd_ack_i)       ovr_q <= 1'b1;
            else if (rd_en_i && rd_addr_i == ADDR_STAT)   ovr_q <= 1'b0;

            if (rd_en_i) rdata_q <= (rd_addr_i == ADDR_STAT) ? status_w : hold_q;
        end
    end

    assign hold_o    = hold_q;
    assign avail_o   = avail_q;
    assign overrun_o = ovr_q;
    assign rd_data_o = rdata_q;

endmodule

// File: rtl/ps2_rx_hold.sv
module ps2_rx_hold
    import ps2_rx_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned TIMEOUT_CYC = 12500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kb_clk_i,
    input  logic              kb_dat_i,
    input  logic              rd_ack_i,
    input  logic              rd_en_i,
    input  logic              rd_addr_i,
    output logic [BYTE_W-1:0] rd_data_o,
    output logic              data_avail_o,
    output logic              overrun_o
);
    localparam int unsigned N_LINES = 2;
    localparam int unsigned L_CLK   = 0;
    localparam int unsigned L_DAT   = 1;

    logic [N_LINES-1:0] raw_lines;
    logic [N_LINES-1:0] sync_lvl;
    logic [N_LINES-1:0] sync_fall;

    logic [BYTE_W-1:0]  frame_byte;
    logic               frame_ok;
    logic               frame_bad;
    logic               rx_timeout;
    rx_state_e          rx_state;
    logic [BYTE_W-1:0]  hold_val;

    assign raw_lines = {kb_dat_i, kb_clk_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        ps2_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_i  (raw_lines[g]),
            .level_o (sync_lvl[g]),
            .fall_o  (sync_fall[g])
        );
    end

    ps2_frame_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_stb_i   (sync_fall[L_CLK]),
        .bit_val_i   (sync_lvl[L_DAT]),
        .byte_o      (frame_byte),
        .frame_ok_o  (frame_ok),
        .frame_bad_o (frame_bad),
        .timeout_o   (rx_timeout),
        .state_o     (rx_state)
    );

    ps2_hold_reg u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_vld_i (frame_ok),
        .byte_i     (frame_byte),
        .rd_ack_i   (rd_ack_i),
        .rd_en_i    (rd_en_i),
        .rd_addr_i  (rd_addr_i),
        .hold_o     (hold_val),
        .avail_o    (data_avail_o),
        .overrun_o  (overrun_o),
        .rd_data_o  (rd_data_o)
    );

endmodule

// File: rtl/ps2_rx_hold_chk.sv
module ps2_rx_hold_chk
    import ps2_rx_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rd_ack_i,
    input logic              rd_en_i,
    input logic              rd_addr_i,
    input logic              data_avail_o,
    input logic              overrun_o,
    input logic [BYTE_W-1:0] frame_byte,
    input logic              frame_ok,
    input logic              frame_bad,
    input logic              rx_timeout,
    input rx_state_e         rx_state,
    input logic [BYTE_W-1:0] hold_val
);
    // R2: an accepted frame loads its byte and raises data-available
    p_load_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |=> (data_avail_o && hold_val == $past(frame_byte)));

    // R3/R4: a dropped frame leaves the holding register and flag untouched
    p_drop_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_bad && !rd_ack_i) |=> ($stable(hold_val) && $stable(data_avail_o)));

    // R3/R4: a frame is either accepted or dropped, never both
    p_ok_bad_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_ok, frame_bad}));

    // R6: an acknowledge without a new byte clears the flag
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ack_i && !frame_ok) |=> !data_avail_o);

    // R6: the flag does not move without a byte or an acknowledge
    p_avail_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_ack_i && !frame_ok) |=> $stable(data_avail_o));

    // R7: a byte over an unread one raises overrun
    p_overrun_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_ok && data_avail_o && !rd_ack_i) |=> overrun_o);

    // R8: without a status read, overrun never falls
    p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en_i && rd_addr_i == ADDR_STAT) |=> !$fell(overrun_o));

    // R9: a timeout sends the receiver back to idle
    p_timeout_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_timeout |=> (rx_state == ST_IDLE));

endmodule

bind ps2_rx_hold ps2_rx_hold_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_ack_i     (rd_ack_i),
    .rd_en_i      (rd_en_i),
    .rd_addr_i    (rd_addr_i),
    .data_avail_o (data_avail_o),
    .overrun_o    (overrun_o),
    .frame_byte   (frame_byte),
    .frame_ok     (frame_ok),
    .frame_bad    (frame_bad),
    .rx_timeout   (rx_timeout),
    .rx_state     (rx_state),
    .hold_val     (hold_val)
);

// File: tb/ps2_rx_hold_tb_top.sv
module ps2_rx_hold_tb_top;

    localparam int TMO = 2000;
    localparam int HP  = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       kb_clk = 1'b1;
    logic       kb_dat = 1'b1;
    logic       rd_ack = 1'b0;
    logic       rd_en = 1'b0;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic       avail;
    logic       ovr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;   // 125 MHz

    ps2_rx_hold #(.SYNC_STAGES(2), .TIMEOUT_CYC(TMO)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .kb_clk_i     (kb_clk),
        .kb_dat_i     (kb_dat),
        .rd_ack_i     (rd_ack),
        .rd_en_i      (rd_en),
        .rd_addr_i    (rd_addr),
        .rd_data_o    (rd_data),
        .data_avail_o (avail),
        .overrun_o    (ovr)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic send_bits(input logic [10:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            kb_dat = bits[i];
            repeat (HP/2) @(posedge clk);
            kb_clk = 1'b0;
            repeat (HP) @(posedge clk);
            kb_clk = 1'b1;
            repeat (HP/2) @(posedge clk);
        end
        kb_dat = 1'b1;
        repeat (10) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] b, input bit bad_par, input bit bad_stop);
        logic par;
        par = ~(^b) ^ bad_par;
        send_bits({~bad_stop, par, b, 1'b0}, 11);
    endtask

    task automatic bus_read(input logic addr, output logic [7:0] val);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = addr;
        @(negedge clk);
        rd_en = 1'b0;
        val = rd_data;
    endtask

    task automatic ack_pulse();
        @(negedge clk);
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 avail", {7'b0, avail}, 8'h00);
        chk("R1 overrun", {7'b0, ovr}, 8'h00);
        chk("R1 rd_data", rd_data, 8'h00);
        bus_read(1'b0, v); chk("R1 hold", v, 8'h00);
        bus_read(1'b1, v); chk("R1 status", v, 8'h00);
    endtask

    task automatic t_good_and_ack();
        logic [7:0] v;
        send_frame(8'hA5, 0, 0);
        chk("R2 avail", {7'b0, avail}, 8'h01);
        bus_read(1'b0, v); chk("R2 byte", v, 8'hA5);
        bus_read(1'b1, v); chk("R8 status avail", v, 8'h01);
        ack_pulse();
        chk("R6 avail cleared", {7'b0, avail}, 8'h00);
        bus_read(1'b0, v); chk("R6 hold kept", v, 8'hA5);
    endtask

    task automatic t_bad_parity();
        logic [7:0] v;
        send_frame(8'h3C, 1, 0);
        chk("R3 avail", {7'b0, avail}, 8'h00);
        bus_read(1'b0, v); chk("R3 hold", v, 8'hA5);
    endtask

    task automatic t_bad_stop();
        logic [7:0] v;
        send_frame(8'h81, 0, 1);
        chk("R4 avail", {7'b0, avail}, 8'h00);
        bus_read(1'b0, v); chk("R4 hold", v, 8'hA5);
    endtask

    task automatic t_false_start();
        logic [7:0] v;
        send_bits(11'h7FF, 1);
        chk("R5 no frame", {7'b0, avail}, 8'h00);
        send_frame(8'h0F, 0, 0);
        bus_read(1'b0, v); chk("R5 byte", v, 8'h0F);
        ack_pulse();
    endtask

    task automatic t_overrun();
        logic [7:0] v;
        send_frame(8'h11, 0, 0);
        send_frame(8'h22, 0, 0);
        chk("R7 overrun pin", {7'b0, ovr}, 8'h01);
        bus_read(1'b0, v); chk("R7 overwrite", v, 8'h22);
        bus_read(1'b1, v); chk("R7 status", v, 8'h03);
        bus_read(1'b1, v); chk("R8 overrun cleared", v, 8'h01);
        ack_pulse();
    endtask

    task automatic t_timeout();
        logic [7:0] v;
        send_bits(11'h7FE, 4);
        repeat (TMO + 200) @(posedge clk);
        send_frame(8'h6E, 0, 0);
        bus_read(1'b0, v); chk("R9 byte after timeout", v, 8'h6E);
        bus_read(1'b1, v); chk("R9 status", v, 8'h01);
        ack_pulse();
    endtask

    initial begin
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        t_reset();
        t_good_and_ack();
        t_bad_parity();
        t_bad_stop();
        t_false_start();
        t_overrun();
        t_timeout();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule